// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block gathers a set of interrupt request lines (32 by default) into a status register. It masks the status with an enable register to form a pending set, and it drives a single request line to the processor. It also reports, as a vector number, the lowest-numbered source that is pending. Software sees eight word registers through a simple register port. The port has a write strobe, a byte address whose two low bits are dropped, write data, and registered read data.

A parameter vector fixes each source as level type or edge type at build time. A level source's status bit copies the input. An edge source's status bit is set by a rising transition and stays set until software acknowledges it. A master register carries two separate gates: bit 1 allows inputs to be captured into status, and bit 0 allows the processor output. Acknowledge, set-enable and clear-enable are write-only aliases, so software can change single bits without a read-modify-write sequence.

All outputs are flops. Every register, the pending set, the vector and the output reflect a write or an input sample at the same clock edge that takes it in.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset, status, enable and master are zero, the output is low, the vector reads all ones and read data is zero.
- R2: The word offset is the byte address shifted right by two, so the two low address bits are ignored. Offsets: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Read data appears one cycle after the address and shows the register contents from before any write in that same cycle.
- R3: Pending always equals status AND enable, updated at the same edge as any write or input capture. Writes to the pending and vector offsets have no effect.
- R4: The vector is the index of the lowest set bit of pending (bit 0 has the highest priority), or all ones when pending is zero.
- R5: The output is high exactly when master bit 0 and master bit 1 are both set and pending is nonzero.
- R6: A write to offset 3 clears each status bit written as 1 and leaves the other status bits alone.
- R7: A write to offset 4 ORs the data into enable. A write to offset 5 clears each enable bit written as 1.
- R8: Writes to offsets 0, 2 and 7 store the full data word in status, enable and master respectively.
- R9: While master bit 1, as held before the current edge, is clear, the inputs do not change status.
- R10: For a level source (kind bit 0) with capture allowed, the status bit takes the input value, which overrides a write to status or an acknowledge in the same cycle.
- R11: For an edge source (kind bit 1) with capture allowed, the status bit is set when the input is high and was low one cycle earlier. The input never clears it. The previous input value is sampled every cycle, even while capture is blocked. A rising edge wins over an acknowledge of the same bit in the same cycle.
- R12: Reads at offsets 3, 4, 5 and 8 or above return zero. Writes at offsets 8 or above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | NSRC | Write data |
| rd_data | output | NSRC | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec | output | NSRC | Lowest pending source index, all ones when none |

## Verification
If the status, enable or master state inside the block is wrong, the error reaches irq_o and irq_vec at the very next edge, because both are recomputed from the next state at each edge. A reference model in the bench compares irq_o, irq_vec and rd_data on every cycle. A lost edge, a stale level bit, or a wrong alias decode therefore shows up within one clock of the stimulus. Read-back of each register confirms hidden state that the output gating would otherwise mask.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  typedef enum logic [2:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_EN     = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam int MST_OUT_BIT = 0;
  localparam int MST_CAP_BIT = 1;

endpackage

// File: rtl/vic_lowest_index.sv
module vic_lowest_index #(
  parameter int N     = 32,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_in,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Scan from the top down so that the lowest set bit is the last one assigned.
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vic_src_capture.sv
module vic_src_capture #(
  parameter int           NSRC     = 32,
  parameter logic [NSRC-1:0] SRC_KIND = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            cap_en,
  input  logic [NSRC-1:0] st_base,
  output logic [NSRC-1:0] st_next
);

  logic [NSRC-1:0] src_prev;

  // The previous sample is kept every cycle, so a rise seen while capture is blocked is lost.
  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (SRC_KIND[g]) begin : g_edge
      assign st_next[g] = st_base[g] | (cap_en & src_i[g] & ~src_prev[g]);
    end else begin : g_level
      assign st_next[g] = cap_en ? src_i[g] : st_base[g];
    end
  end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vec_irq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   st_cap,
  input  logic [NSRC-1:0]   pend_q,
  input  logic [NSRC-1:0]   vec_q,
  output logic [NSRC-1:0]   st_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   mer_q,
  output logic [NSRC-1:0]   st_base,
  output logic [NSRC-1:0]   en_n,
  output logic [NSRC-1:0]   mer_n,
  output logic [NSRC-1:0]   rd_data
);

  logic     in_map;
  reg_sel_e sel;

  assign in_map = (word[WORD_W-1:3] == '0);
  assign sel    = reg_sel_e'(word[2:0]);

  always_comb begin
    st_base = st_q;
    en_n    = en_q;
    mer_n   = mer_q;
    if (wr_en && in_map) begin
      unique case (sel)
        SEL_STAT:   st_base = wdata;
        SEL_EN:     en_n    = wdata;
        SEL_ACK:    st_base = st_q & ~wdata;
        SEL_SETEN:  en_n    = en_q | wdata;
        SEL_CLREN:  en_n    = en_q & ~wdata;
        SEL_MASTER: mer_n   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      en_q  <= '0;
      mer_q <= '0;
    end else begin
      st_q  <= st_cap;
      en_q  <= en_n;
      mer_q <= mer_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (!in_map) begin
      rd_data <= '0;
    end else begin
      unique case (sel)
        SEL_STAT:   rd_data <= st_q;
        SEL_PEND:   rd_data <= pend_q;
        SEL_EN:     rd_data <= en_q;
        SEL_VEC:    rd_data <= vec_q;
        SEL_MASTER: rd_data <= mer_q;
        default:    rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int              NSRC     = 32,
  parameter int              ADDR_W   = 8,
  parameter logic [NSRC-1:0] SRC_KIND = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rd_data,
  output logic              irq_o,
  output logic [NSRC-1:0]   irq_vec
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  st_q, en_q, mer_q;
  logic [NSRC-1:0]  st_base, st_cap, en_n, mer_n;
  logic [NSRC-1:0]  pend_n, pend_q, vec_n, vec_q;
  logic [IDX_W-1:0] low_idx;
  logic             low_any;
  logic             irq_n, irq_q;

  vic_regs #(.NSRC(NSRC), .WORD_W(WORD_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .word    (addr[ADDR_W-1:2]),
    .wdata   (wdata),
    .st_cap  (st_cap),
    .pend_q  (pend_q),
    .vec_q   (vec_q),
    .st_q    (st_q),
    .en_q    (en_q),
    .mer_q   (mer_q),
    .st_base (st_base),
    .en_n    (en_n),
    .mer_n   (mer_n),
    .rd_data (rd_data)
  );

  vic_src_capture #(.NSRC(NSRC), .SRC_KIND(SRC_KIND)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src_i),
    .cap_en  (mer_q[MST_CAP_BIT]),
    .st_base (st_base),
    .st_next (st_cap)
  );

  assign pend_n = st_cap & en_n;

  vic_lowest_index #(.N(NSRC), .IDX_W(IDX_W)) u_enc (
    .vec_in (pend_n),
    .idx    (low_idx),
    .any    (low_any)
  );

  assign vec_n = low_any ? NSRC'(low_idx) : '1;
  assign irq_n = mer_n[MST_OUT_BIT] & mer_n[MST_CAP_BIT] & low_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      vec_q  <= '1;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      vec_q  <= vec_n;
      irq_q  <= irq_n;
    end
  end

  assign irq_o   = irq_q;
  assign irq_vec = vec_q;

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic              irq_o,
  input logic [NSRC-1:0]   irq_vec,
  input logic [NSRC-1:0]   st_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   mer_q,
  input logic [NSRC-1:0]   pend_q
);

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && irq_vec == '1 && st_q == '0 && en_q == '0 && mer_q == '0));

  a_r3_pend_is_masked: assert property (@(posedge clk) disable iff (rst)
    pend_q == (st_q & en_q));

  a_r4_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    (irq_vec == '1) || (irq_vec < NSRC));

  a_r5_output_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (mer_q[0] && mer_q[1] && irq_vec != '1));

  a_r7_set_enable: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:2] == 4) |=> ((en_q & $past(wdata)) == $past(wdata)));

  a_r9_capture_blocked: assert property (@(posedge clk) disable iff (rst)
    (!mer_q[1] && !wr_en) |=> $stable(st_q));

  a_r12_outside_map: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:5] != '0) |=> ($stable(en_q) && $stable(mer_q)));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq_o   (irq_o),
  .irq_vec (irq_vec),
  .st_q    (st_q),
  .en_q    (en_q),
  .mer_q   (mer_q),
  .pend_q  (pend_q)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

  localparam int          NSRC = 32;
  localparam int          AW   = 8;
  localparam logic [31:0] KIND = 32'hFFFF_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   src_i = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data, irq_vec;
  logic          irq_o;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  logic [31:0] m_st = '0, m_en = '0, m_mer = '0, m_prev = '0;

  vec_irq_ctrl #(.NSRC(NSRC), .ADDR_W(AW), .SRC_KIND(KIND)) uut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq_o(irq_o), .irq_vec(irq_vec)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] low_of(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(input int w);
    case (w)
      0: return m_st;
      1: return m_st & m_en;
      2: return m_en;
      6: return low_of(m_st & m_en);
      7: return m_mer;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: model the edge from the inputs now driven, then compare all outputs.
  task automatic step(input string tag);
    logic [31:0] exp_rd, st, en, mer;
    int w;
    w      = int'(addr) >> 2;
    exp_rd = model_read(w);
    st = m_st; en = m_en; mer = m_mer;
    if (wr_en && w < 8) begin
      case (w)
        0: st  = wdata;
        2: en  = wdata;
        3: st  = st & ~wdata;
        4: en  = en | wdata;
        5: en  = en & ~wdata;
        7: mer = wdata;
        default: ;
      endcase
    end
    if (m_mer[1]) begin
      for (int i = 0; i < 32; i++) begin
        if (KIND[i]) begin
          if (src_i[i] && !m_prev[i]) st[i] = 1'b1;
        end else begin
          st[i] = src_i[i];
        end
      end
    end
    m_prev = src_i; m_st = st; m_en = en; m_mer = mer;
    @(posedge clk);
    @(negedge clk);
    check({tag, "/R5 irq"}, {31'h0, irq_o},
          {31'h0, m_mer[0] && m_mer[1] && ((m_st & m_en) != 0)});
    check({tag, "/R4 vec"}, irq_vec, low_of(m_st & m_en));
    check({tag, " rd"}, rd_data, exp_rd);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    wr_en = 1'b1; addr = a; wdata = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    addr = a;
    step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state seen at the ports
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 vec", irq_vec, 32'hFFFF_FFFF);
    check("R1 rd", rd_data, 32'h0);
    rd(8'h18, "R1");
    rd(8'h00, "R1");

    // R8 / R2: master write, read data shows pre-write value then new value
    wr(8'h1C, 32'h3, "R2");
    rd(8'h1C, "R8");

    // R10: level source 3 follows input
    src_i[3] = 1'b1; rd(8'h00, "R10");
    wr(8'h10, 32'h0000_0108, "R7");
    rd(8'h04, "R3");
    src_i[3] = 1'b0; rd(8'h00, "R10");

    // R11: edge source 20 latches a one-cycle pulse
    wr(8'h10, 32'h0030_0000, "R7");
    src_i[20] = 1'b1; rd(8'h00, "R11");
    src_i[20] = 1'b0; rd(8'h00, "R11");
    rd(8'h18, "R4");
    // R4: level source 8 has priority over 20
    src_i[8] = 1'b1; rd(8'h18, "R4");
    src_i[8] = 1'b0; rd(8'h18, "R4");

    // R6: acknowledge clears only written bits
    wr(8'h0C, 32'h0010_0000, "R6");
    rd(8'h00, "R6");

    // R11: edge and ack on bit 21 together, edge wins
    src_i[21] = 1'b1;
    wr(8'h0C, 32'h0020_0000, "R11");
    rd(8'h00, "R11");
    // R11: input held high does not re-set after ack
    wr(8'h0C, 32'h0020_0000, "R11");
    src_i[21] = 1'b0; rd(8'h00, "R11");

    // R10: ack of a high level source has no lasting effect
    src_i[3] = 1'b1; rd(8'h00, "R10");
    wr(8'h0C, 32'h0000_0008, "R10");
    rd(8'h00, "R10");

    // R7: clear enable
    wr(8'h14, 32'h0000_0008, "R7");
    rd(8'h08, "R7");
    wr(8'h10, 32'h0000_0008, "R7");

    // R5: output bit 0 off
    wr(8'h1C, 32'h2, "R5");
    rd(8'h04, "R5");
    wr(8'h1C, 32'h3, "R5");

    // R9: capture bit off, inputs ignored, missed rise not recovered
    wr(8'h1C, 32'h1, "R9");
    src_i[3] = 1'b0; src_i[22] = 1'b1; src_i[5] = 1'b1;
    rd(8'h00, "R9");
    rd(8'h00, "R9");
    wr(8'h1C, 32'h3, "R9");
    rd(8'h00, "R9");
    src_i[22] = 1'b0; src_i[5] = 1'b0; rd(8'h00, "R9");

    // R3: writes to pending and vector offsets have no effect
    wr(8'h04, 32'hFFFF_FFFF, "R3");
    wr(8'h18, 32'h0000_0000, "R3");
    rd(8'h04, "R3");

    // R12: reads of alias and out-of-map offsets, writes out of map
    rd(8'h0C, "R12"); rd(8'h10, "R12"); rd(8'h14, "R12");
    wr(8'h20, 32'hFFFF_FFFF, "R12");
    wr(8'h3C, 32'h0, "R12");
    rd(8'h24, "R12");
    rd(8'h08, "R12");

    // R8: direct status write on edge bits, then R2 low address bits ignored
    wr(8'h00, 32'h0040_0000, "R8");
    wr(8'h0A, 32'h0040_0000, "R8");
    rd(8'h01, "R2");
    wr(8'h1F, 32'h0, "R2");
    rd(8'h1D, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule